// File: doc/BRIEF.md
# SPI Flash Chunking Sequencer

This block sits between a host that asks for whole flash operations and a command shift engine that can only move an opcode, an optional address and a few data bytes per transaction. The host presents one request: an opcode, a 24-bit flash address, a write-byte length and a read-byte length. The sequencer breaks the request into engine transactions of at most `CHUNK_BYTES` data bytes each. It collects write bytes from a valid/ready input stream and sends read bytes out on a valid/ready output stream. It also moves the flash address forward after every transaction.

Page-program requests get extra steps between chunks. After each chunk that is not the last, the sequencer polls the flash status register until the busy bit clears. It then sends a write-enable command and only after that sends the next chunk. A fast-read request is turned into a plain read at the same address, so no dummy byte is needed. Requests with an unknown opcode, or with both read and write lengths non-zero, are refused with a one-clock illegal pulse. A one-clock done pulse marks the end of each accepted request.

Engine handshake: the sequencer raises `eng_start` for one clock, with all `eng_*` command fields valid in that clock. The engine raises `eng_busy` at the next clock edge. When `eng_busy` falls, `eng_rdata` must already hold the received bytes, with the first byte in bits [7:0].

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `eng_start`, `done`, `illegal`, `rd_valid` and `wr_ready` are all 0.
- R2: Each data transaction carries min(`CHUNK_BYTES`, bytes still remaining) data bytes. For that transaction, `eng_rxcnt` is the read byte count and `eng_txcnt` = 1 + `eng_alen` + the write byte count.
- R3: After each data transaction, the address of the next transaction is the previous address plus the number of data bytes just moved.
- R4: For page program (0x02), every chunk except the last is followed by status-read transactions and then a write-enable transaction, before the next chunk starts. A status read uses opcode 0x05, `eng_txcnt`=1, `eng_rxcnt`=1, and is repeated while bit 0 of `eng_rdata` is 1. The write enable uses opcode 0x06, `eng_txcnt`=1, `eng_rxcnt`=0. No status read follows the last chunk.
- R5: A fast read (0x0B) is issued as opcode 0x03 at the same address, with `eng_alen`=3 and no dummy byte in `eng_txcnt`.
- R6: A request whose opcode is outside {0x06, 0x04, 0x05, 0x01, 0x03, 0x0B, 0x02, 0xD8, 0xC7, 0x9F, 0xAB}, or whose read and write lengths are both non-zero, produces a one-clock `illegal` pulse. Such a request starts no engine transaction and produces no `done`.
- R7: `done` is a single-clock pulse, issued once per accepted request, after the last read byte of the final chunk has been handed over.
- R8: Opcodes 0x06, 0x04 and 0xC7 with zero lengths go out as one transaction with `eng_txcnt`=1, `eng_alen`=0, `eng_rxcnt`=0. Sector erase (0xD8) goes out as one transaction with `eng_alen`=3 and `eng_txcnt`=4.
- R9: Write bytes are packed into `eng_data` in stream order, the first byte in bits [7:0]. Read bytes leave in order starting from `eng_rdata[7:0]`. `rd_data` holds steady while `rd_valid` is 1 and `rd_ready` is 0.
- R10: `req_ready` goes low in the clock after a legal request is accepted and stays low until that request is done. `eng_start` never lasts longer than one clock and is never raised while `eng_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_opcode | input | 8 | Flash opcode of the request |
| req_addr | input | ADDR_W | Starting flash address |
| req_wr_len | input | LEN_W | Number of bytes to write |
| req_rd_len | input | LEN_W | Number of bytes to read |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken by host |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-clock request completion pulse |
| illegal | output | 1 | One-clock request rejection pulse |
| eng_start | output | 1 | One-clock engine launch |
| eng_opcode | output | 8 | Opcode for the engine |
| eng_addr | output | ADDR_W | Flash address for the engine |
| eng_alen | output | 2 | Number of address bytes to shift (0 or 3) |
| eng_data | output | 8*CHUNK_BYTES | Write data, first byte in bits [7:0] |
| eng_txcnt | output | TXC_W | Total bytes to transmit: opcode, address and data |
| eng_rxcnt | output | CW | Bytes to receive |
| eng_busy | input | 1 | Engine transaction in progress |
| eng_rdata | input | 8*CHUNK_BYTES | Received bytes, first byte in bits [7:0] |

## Verification
The bench builds the block with `CHUNK_BYTES`=4, `ADDR_W`=24 and a narrowed `LEN_W`=8. With these values, a 10-byte read covers two full chunks plus a 2-byte tail, and a 6-byte program covers one full chunk plus a partial one. A behavioural engine model answers status reads as busy twice after each program, so the repeated-poll path runs before the write enable. Read back-pressure is toggled every clock during the long read, to exercise holding of the output byte.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT  = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_RDID  = 8'hAB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_FILL,
    ST_ARM,
    ST_WAIT,
    ST_DRAIN
  } seq_state_t;

  typedef enum logic [1:0] {
    K_DATA,
    K_POLL,
    K_WREN
  } xact_kind_t;

endpackage

// File: rtl/spi_op_decode.sv
module spi_op_decode
  import spi_seq_pkg::*;
(
  input  logic [7:0] op_in,
  output logic       legal,
  output logic [1:0] alen,
  output logic       prog,
  output logic [7:0] op_out
);

  always_comb begin
    legal  = 1'b1;
    alen   = 2'd0;
    prog   = 1'b0;
    op_out = op_in;
    case (op_in)
      OP_WREN, OP_WRDI, OP_CHIP, OP_RDSR, OP_WRSR, OP_JEDEC: ;
      OP_READ, OP_SECT, OP_RDID: alen = 2'd3;
      OP_FAST: begin
        alen   = 2'd3;
        op_out = OP_READ;
      end
      OP_PROG: begin
        alen = 2'd3;
        prog = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/spi_tx_gather.sv
module spi_tx_gather #(
  parameter  int NBYTES = 4,
  localparam int CW     = $clog2(NBYTES + 1),
  localparam int DW     = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] need,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          full,
  output logic [DW-1:0] word
);

  logic [CW-1:0] got_q;
  logic [CW-1:0] need_q;
  logic [7:0]    lane_q [NBYTES];

  assign in_ready = (got_q != need_q);
  assign full     = (got_q == need_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      got_q  <= '0;
      need_q <= '0;
    end else if (load) begin
      got_q  <= '0;
      need_q <= need;
    end else if (in_valid && in_ready) begin
      got_q <= got_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || load) begin
        lane_q[i] <= 8'h00;
      end else if (in_valid && in_ready && got_q == CW'(i)) begin
        lane_q[i] <= in_data;
      end
    end
    assign word[8*i +: 8] = lane_q[i];
  end

endmodule

// File: rtl/spi_rx_drain.sv
module spi_rx_drain #(
  parameter  int NBYTES = 4,
  localparam int CW     = $clog2(NBYTES + 1),
  localparam int DW     = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] count,
  input  logic [DW-1:0] word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          empty
);

  logic [DW-1:0] word_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx_q;

  assign out_valid = (idx_q != cnt_q);
  assign empty     = (idx_q == cnt_q);
  assign out_data  = word_q[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= word;
      cnt_q  <= count;
      idx_q  <= '0;
    end else if (out_valid && out_ready) begin
      word_q <= word_q >> 8;
      idx_q  <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter  int ADDR_W      = 24,
  parameter  int LEN_W       = 12,
  parameter  int CHUNK_BYTES = 4,
  parameter  int BUSY_BIT    = 0,
  localparam int CW          = $clog2(CHUNK_BYTES + 1),
  localparam int TXC_W       = $clog2(CHUNK_BYTES + 5),
  localparam int DW          = 8 * CHUNK_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_wr_len,
  input  logic [LEN_W-1:0]  req_rd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              illegal,
  output logic              eng_start,
  output logic [7:0]        eng_opcode,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [1:0]        eng_alen,
  output logic [DW-1:0]     eng_data,
  output logic [TXC_W-1:0]  eng_txcnt,
  output logic [CW-1:0]     eng_rxcnt,
  input  logic              eng_busy,
  input  logic [DW-1:0]     eng_rdata
);

  seq_state_t        state;
  xact_kind_t        kind;
  logic [7:0]        op_q;
  logic [1:0]        alen_q;
  logic              prog_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  wr_rem;
  logic [LEN_W-1:0]  rd_rem;
  logic [CW-1:0]     chunk_tx;
  logic [CW-1:0]     chunk_rx;
  logic [CW-1:0]     tx_n;
  logic [CW-1:0]     rx_n;

  logic              dec_legal;
  logic [1:0]        dec_alen;
  logic              dec_prog;
  logic [7:0]        dec_op;

  logic              g_load;
  logic              g_full;
  logic [DW-1:0]     g_word;
  logic              d_load;
  logic              d_empty;

  spi_op_decode u_dec (
    .op_in  (req_opcode),
    .legal  (dec_legal),
    .alen   (dec_alen),
    .prog   (dec_prog),
    .op_out (dec_op)
  );

  assign tx_n = (wr_rem > LEN_W'(CHUNK_BYTES)) ? CW'(CHUNK_BYTES) : CW'(wr_rem);
  assign rx_n = (rd_rem > LEN_W'(CHUNK_BYTES)) ? CW'(CHUNK_BYTES) : CW'(rd_rem);

  assign g_load = (state == ST_PREP);
  assign d_load = (state == ST_WAIT) && !eng_busy && (kind == K_DATA);

  spi_tx_gather #(.NBYTES(CHUNK_BYTES)) u_gather (
    .clk      (clk),
    .rst      (rst),
    .load     (g_load),
    .need     (tx_n),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .in_data  (wr_data),
    .full     (g_full),
    .word     (g_word)
  );

  spi_rx_drain #(.NBYTES(CHUNK_BYTES)) u_drain (
    .clk       (clk),
    .rst       (rst),
    .load      (d_load),
    .count     (chunk_rx),
    .word      (eng_rdata),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .out_data  (rd_data),
    .empty     (d_empty)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kind       <= K_DATA;
      op_q       <= '0;
      alen_q     <= '0;
      prog_q     <= 1'b0;
      addr_q     <= '0;
      wr_rem     <= '0;
      rd_rem     <= '0;
      chunk_tx   <= '0;
      chunk_rx   <= '0;
      done       <= 1'b0;
      illegal    <= 1'b0;
      eng_start  <= 1'b0;
      eng_opcode <= '0;
      eng_addr   <= '0;
      eng_alen   <= '0;
      eng_data   <= '0;
      eng_txcnt  <= '0;
      eng_rxcnt  <= '0;
    end else begin
      done      <= 1'b0;
      illegal   <= 1'b0;
      eng_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!dec_legal || (req_wr_len != '0 && req_rd_len != '0)) begin
              illegal <= 1'b1;
            end else begin
              op_q   <= dec_op;
              alen_q <= dec_alen;
              prog_q <= dec_prog;
              addr_q <= req_addr;
              wr_rem <= req_wr_len;
              rd_rem <= req_rd_len;
              state  <= ST_PREP;
            end
          end
        end
        ST_PREP: begin
          chunk_tx <= tx_n;
          chunk_rx <= rx_n;
          wr_rem   <= wr_rem - LEN_W'(tx_n);
          rd_rem   <= rd_rem - LEN_W'(rx_n);
          state    <= ST_FILL;
        end
        ST_FILL: begin
          if (g_full) begin
            kind       <= K_DATA;
            eng_start  <= 1'b1;
            eng_opcode <= op_q;
            eng_addr   <= addr_q;
            eng_alen   <= alen_q;
            eng_data   <= g_word;
            eng_txcnt  <= TXC_W'(1) + TXC_W'(alen_q) + TXC_W'(chunk_tx);
            eng_rxcnt  <= chunk_rx;
            state      <= ST_ARM;
          end
        end
        ST_ARM: state <= ST_WAIT;
        ST_WAIT: begin
          if (!eng_busy) begin
            case (kind)
              K_DATA: begin
                addr_q <= addr_q + ADDR_W'(chunk_tx) + ADDR_W'(chunk_rx);
                state  <= ST_DRAIN;
              end
              K_POLL: begin
                eng_start <= 1'b1;
                eng_alen  <= 2'd0;
                eng_data  <= '0;
                eng_txcnt <= TXC_W'(1);
                state     <= ST_ARM;
                if (eng_rdata[BUSY_BIT]) begin
                  kind       <= K_POLL;
                  eng_opcode <= OP_RDSR;
                  eng_rxcnt  <= CW'(1);
                end else begin
                  kind       <= K_WREN;
                  eng_opcode <= OP_WREN;
                  eng_rxcnt  <= '0;
                end
              end
              default: state <= ST_PREP;
            endcase
          end
        end
        ST_DRAIN: begin
          if (d_empty) begin
            if (wr_rem == '0 && rd_rem == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (prog_q) begin
              kind       <= K_POLL;
              eng_start  <= 1'b1;
              eng_opcode <= OP_RDSR;
              eng_alen   <= 2'd0;
              eng_data   <= '0;
              eng_txcnt  <= TXC_W'(1);
              eng_rxcnt  <= CW'(1);
              state      <= ST_ARM;
            end else begin
              state <= ST_PREP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk #(
  parameter int CHUNK_BYTES = 4,
  parameter int CW          = 3,
  parameter int TXC_W       = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic             illegal,
  input logic             eng_start,
  input logic             eng_busy,
  input logic [1:0]       eng_alen,
  input logic [TXC_W-1:0] eng_txcnt,
  input logic [CW-1:0]    eng_rxcnt,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data
);

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  assert_start_engine_idle_R10: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !eng_busy);

  assert_accept_drops_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready || illegal));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_chunk_bound_R2: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (int'(eng_rxcnt) <= CHUNK_BYTES) &&
                  (int'(eng_txcnt) <= 1 + int'(eng_alen) + CHUNK_BYTES));

  assert_no_duplex_R6: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (eng_rxcnt == '0) || (int'(eng_txcnt) == 1 + int'(eng_alen)));

  assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (req_ready && !done && !eng_start));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

bind spi_flash_seq spi_flash_seq_chk #(
  .CHUNK_BYTES (CHUNK_BYTES),
  .CW          (CW),
  .TXC_W       (TXC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .illegal   (illegal),
  .eng_start (eng_start),
  .eng_busy  (eng_busy),
  .eng_alen  (eng_alen),
  .eng_txcnt (eng_txcnt),
  .eng_rxcnt (eng_rxcnt),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;

  localparam int AW = 24;
  localparam int LW = 8;
  localparam int CB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [7:0]    req_opcode = 8'h00;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_wr_len = '0;
  logic [LW-1:0] req_rd_len = '0;
  logic          wr_valid = 1'b1;
  logic          wr_ready;
  logic [7:0]    wr_data;
  logic          rd_valid;
  logic          rd_ready = 1'b1;
  logic [7:0]    rd_data;
  logic          done;
  logic          illegal;
  logic          eng_start;
  logic [7:0]    eng_opcode;
  logic [AW-1:0] eng_addr;
  logic [1:0]    eng_alen;
  logic [DW-1:0] eng_data;
  logic [3:0]    eng_txcnt;
  logic [2:0]    eng_rxcnt;
  logic          eng_busy = 1'b0;
  logic [DW-1:0] eng_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit bp = 1'b0;

  always #10 clk = ~clk;

  spi_flash_seq #(.ADDR_W(AW), .LEN_W(LW), .CHUNK_BYTES(CB)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_wr_len(req_wr_len), .req_rd_len(req_rd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .illegal(illegal),
    .eng_start(eng_start), .eng_opcode(eng_opcode), .eng_addr(eng_addr),
    .eng_alen(eng_alen), .eng_data(eng_data), .eng_txcnt(eng_txcnt),
    .eng_rxcnt(eng_rxcnt), .eng_busy(eng_busy), .eng_rdata(eng_rdata)
  );

  // flash and engine model
  logic [7:0]    mem [0:255];
  int            poll_left = 0;
  logic [2:0]    lat = 3'd0;
  logic [7:0]    c_op;
  logic [AW-1:0] c_addr;
  logic [1:0]    c_alen;
  logic [3:0]    c_tx;
  logic [2:0]    c_rx;
  logic [DW-1:0] c_data;
  logic [DW-1:0] mres;

  logic [7:0]    lg_op   [0:63];
  logic [AW-1:0] lg_addr [0:63];
  logic [1:0]    lg_alen [0:63];
  logic [3:0]    lg_tx   [0:63];
  logic [2:0]    lg_rx   [0:63];
  logic [DW-1:0] lg_data [0:63];
  int            lg_n = 0;

  always @(posedge clk) begin
    if (rst) begin
      eng_busy <= 1'b0;
    end else if (eng_start) begin
      eng_busy <= 1'b1;
      lat      <= 3'd3;
      c_op <= eng_opcode; c_addr <= eng_addr; c_alen <= eng_alen;
      c_tx <= eng_txcnt;  c_rx <= eng_rxcnt;  c_data <= eng_data;
      if (lg_n < 64) begin
        lg_op[lg_n] <= eng_opcode; lg_addr[lg_n] <= eng_addr;
        lg_alen[lg_n] <= eng_alen; lg_tx[lg_n] <= eng_txcnt;
        lg_rx[lg_n] <= eng_rxcnt;  lg_data[lg_n] <= eng_data;
      end
      lg_n <= lg_n + 1;
    end else if (eng_busy) begin
      if (lat != 3'd0) begin
        lat <= lat - 3'd1;
      end else begin
        mres = '0;
        case (c_op)
          8'h03: for (int i = 0; i < int'(c_rx); i++)
                   mres[8*i +: 8] = mem[c_addr[7:0] + 8'(i)];
          8'h02: begin
            for (int i = 0; i < int'(c_tx) - 1 - int'(c_alen); i++)
              mem[c_addr[7:0] + 8'(i)] = c_data[8*i +: 8];
            poll_left = 2;
          end
          8'h05: begin
            mres[0] = (poll_left != 0);
            if (poll_left > 0) poll_left = poll_left - 1;
          end
          8'h9F: mres = 32'h0018_40EF;
          default: mres = '0;
        endcase
        eng_rdata <= mres;
        eng_busy  <= 1'b0;
      end
    end
  end

  // host streams
  logic [7:0] wr_buf [0:63];
  int         wr_idx = 0;
  logic [7:0] rx_buf [0:63];
  int         rx_n = 0;
  int         done_n = 0;
  int         ill_n = 0;

  assign wr_data = wr_buf[wr_idx[5:0]];

  always @(posedge clk) begin
    if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
    if (rd_valid && rd_ready) begin
      rx_buf[rx_n[5:0]] <= rd_data;
      rx_n <= rx_n + 1;
    end
    if (done)    done_n <= done_n + 1;
    if (illegal) ill_n  <= ill_n + 1;
  end

  always @(negedge clk) rd_ready <= bp ? ~rd_ready : 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [AW-1:0] a,
                       input int wl, input int rl, input bit legal);
    int d0 = done_n;
    int i0 = ill_n;
    bit seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_opcode = op; req_addr = a;
    req_wr_len = LW'(wl); req_rd_len = LW'(rl);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (legal) check("R10 ready low after accept", 32'(req_ready), 32'd0);
    for (int k = 0; k < 3000; k++) begin
      if (done_n != d0 || ill_n != i0) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check("R7 request finished", 32'(seen), 32'd1);
    if (legal) check("R7 done low next cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    check("R7 done count", 32'(done_n - d0), legal ? 32'd1 : 32'd0);
    check("R6 illegal count", 32'(ill_n - i0), legal ? 32'd0 : 32'd1);
  endtask

  task automatic t_reset;
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 eng_start", 32'(eng_start), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 illegal", 32'(illegal), 32'd0);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    check("R1 wr_ready", 32'(wr_ready), 32'd0);
  endtask

  task automatic t_read;
    int b = lg_n;
    int r0 = rx_n;
    bp = 1'b1;
    issue(8'h03, 24'h000010, 0, 10, 1'b1);
    bp = 1'b0;
    check("R2 read xact count", 32'(lg_n - b), 32'd3);
    for (int j = 0; j < 3; j++) begin
      check("R2 read rxcnt", 32'(lg_rx[b+j]), (j == 2) ? 32'd2 : 32'd4);
      check("R2 read txcnt", 32'(lg_tx[b+j]), 32'd4);
      check("R3 read addr", 32'(lg_addr[b+j]), 32'h10 + 32'(4*j));
    end
    check("R9 read byte count", 32'(rx_n - r0), 32'd10);
    for (int j = 0; j < 10; j++)
      check("R9 read byte order", 32'(rx_buf[r0+j]), 32'(mem[8'h10 + 8'(j)]));
  endtask

  task automatic t_fast;
    int b = lg_n;
    int r0 = rx_n;
    issue(8'h0B, 24'h000040, 0, 3, 1'b1);
    check("R5 fast xact count", 32'(lg_n - b), 32'd1);
    check("R5 fast opcode", 32'(lg_op[b]), 32'h03);
    check("R5 fast addr", 32'(lg_addr[b]), 32'h40);
    check("R5 fast alen", 32'(lg_alen[b]), 32'd3);
    check("R5 fast txcnt", 32'(lg_tx[b]), 32'd4);
    for (int j = 0; j < 3; j++)
      check("R5 fast data", 32'(rx_buf[r0+j]), 32'(mem[8'h40 + 8'(j)]));
  endtask

  task automatic t_program;
    int b = lg_n;
    int w0 = wr_idx;
    issue(8'h02, 24'h000080, 6, 0, 1'b1);
    check("R4 prog xact count", 32'(lg_n - b), 32'd6);
    check("R2 prog chunk0 txcnt", 32'(lg_tx[b]), 32'd8);
    check("R9 prog chunk0 data", lg_data[b],
          {wr_buf[w0+3], wr_buf[w0+2], wr_buf[w0+1], wr_buf[w0]});
    for (int j = 1; j < 4; j++) begin
      check("R4 poll opcode", 32'(lg_op[b+j]), 32'h05);
      check("R4 poll txcnt", 32'(lg_tx[b+j]), 32'd1);
      check("R4 poll rxcnt", 32'(lg_rx[b+j]), 32'd1);
    end
    check("R4 wren opcode", 32'(lg_op[b+4]), 32'h06);
    check("R4 wren txcnt", 32'(lg_tx[b+4]), 32'd1);
    check("R4 wren rxcnt", 32'(lg_rx[b+4]), 32'd0);
    check("R4 chunk1 opcode", 32'(lg_op[b+5]), 32'h02);
    check("R3 prog chunk1 addr", 32'(lg_addr[b+5]), 32'h84);
    check("R2 prog chunk1 txcnt", 32'(lg_tx[b+5]), 32'd6);
    check("R9 prog chunk1 data", lg_data[b+5], {16'h0, wr_buf[w0+5], wr_buf[w0+4]});
    for (int j = 0; j < 6; j++)
      check("R4 flash content", 32'(mem[8'h80 + 8'(j)]), 32'(wr_buf[w0+j]));
  endtask

  task automatic t_single;
    int b = lg_n;
    issue(8'hC7, 24'h0, 0, 0, 1'b1);
    check("R8 chip erase count", 32'(lg_n - b), 32'd1);
    check("R8 chip erase txcnt", 32'(lg_tx[b]), 32'd1);
    check("R8 chip erase alen", 32'(lg_alen[b]), 32'd0);
    check("R8 chip erase rxcnt", 32'(lg_rx[b]), 32'd0);
    b = lg_n;
    issue(8'hD8, 24'h123456, 0, 0, 1'b1);
    check("R8 sector erase count", 32'(lg_n - b), 32'd1);
    check("R8 sector erase txcnt", 32'(lg_tx[b]), 32'd4);
    check("R8 sector erase alen", 32'(lg_alen[b]), 32'd3);
    check("R8 sector erase addr", 32'(lg_addr[b]), 32'h123456);
  endtask

  task automatic t_illegal;
    int b = lg_n;
    issue(8'h55, 24'h0, 0, 2, 1'b0);
    check("R6 bad opcode no xact", 32'(lg_n - b), 32'd0);
    issue(8'h03, 24'h0, 2, 2, 1'b0);
    check("R6 duplex no xact", 32'(lg_n - b), 32'd0);
    check("R6 ready after reject", 32'(req_ready), 32'd1);
  endtask

  task automatic t_jedec;
    int b = lg_n;
    int r0 = rx_n;
    issue(8'h9F, 24'h0, 0, 3, 1'b1);
    check("R2 id rxcnt", 32'(lg_rx[b]), 32'd3);
    check("R8 id alen", 32'(lg_alen[b]), 32'd0);
    check("R9 id byte0", 32'(rx_buf[r0]), 32'hEF);
    check("R9 id byte1", 32'(rx_buf[r0+1]), 32'h40);
    check("R9 id byte2", 32'(rx_buf[r0+2]), 32'h18);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 64; i++) wr_buf[i] = 8'hA0 + 8'(i * 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_fast();
    t_program();
    t_single();
    t_illegal();
    t_jedec();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule